// File: doc/BRIEF.md
# ADC Conversion Start and Clock Controller

This block decides when a successive-approximation converter starts a conversion and produces the converter's clock enable. In auto mode, a 4-bit select picks one of sixteen raw event flags. Each rising edge of the picked flag can issue a start pulse. One start pulse is allowed per conversion: a start marks the converter busy, and the busy state ends when the converter reports done. Edges that arrive while a conversion is running are lost; they are not queued.

Two of the sixteen select codes are synchronization sources. For these sources a single-shot option allows exactly one conversion. Further edges from either source are then ignored until software reads the result high byte, or until auto mode is turned off.

A 3-bit code sets the divide factor of a free-running clock-enable generator. A high-speed flag is passed through as a status output and does not change the division. All control inputs are registered once inside the block. Each control register resets to zero.

Top module: `adc_trig_ctrl`

## Requirements
- R1: While rst_ni is low, soc_o, busy_o, adc_clk_en_o and high_speed_o are all 0, and every internal control register holds zero.
- R2: When auto mode is on, a rising edge of the selected raw flag raises soc_o for exactly one clock cycle. A rising edge means the flag is 1 at a clock edge and was 0 at the previous clock edge. soc_o rises in the cycle after that clock edge.
- R3: While the registered auto-enable is 0, no edge on any flag produces soc_o.
- R4: Rising edges on flags that are not selected produce no soc_o.
- R5: busy_o goes high together with soc_o and stays high until conv_done_i is sampled high at a clock edge. A selected edge seen while busy_o is high is dropped and is not replayed later.
- R6: With single-shot set and select code 8 or 9 (the synchronization sources), one conversion is started. Later edges from these sources are then ignored until res_hi_rd_i is sampled high.
- R7: Turning the registered auto-enable off clears the single-shot block. After auto mode is turned on again, a sync edge starts a conversion without a read strobe.
- R8: With single-shot clear, every sync-source edge that arrives while the converter is idle starts a conversion.
- R9: Single-shot has no effect on select codes other than 8 and 9.
- R10: adc_clk_en_o is a one-cycle pulse repeating every F cycles. F is 2, 2, 4, 8, 16, 32, 64, 128 for prescaler codes 0 to 7.
- R11: The divider restarts at the clock edge where a new prescaler code is captured. The first pulse after the change comes F cycles after the change edge, where F is the new factor, so no pulse is early.
- R12: high_speed_o follows high_speed_i one cycle later and has no effect on adc_clk_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| auto_en_i | input | 1 | Auto-trigger enable |
| trig_sel_i | input | 4 | Trigger source select |
| single_shot_i | input | 1 | Single-shot enable for sync sources |
| presc_sel_i | input | 3 | Prescaler code |
| high_speed_i | input | 1 | High-speed status bit |
| evt_flags_i | input | 16 | Raw event flags, not gated by interrupt enables |
| res_hi_rd_i | input | 1 | Result high-byte read strobe |
| conv_done_i | input | 1 | Conversion complete from the converter |
| soc_o | output | 1 | Start-of-conversion pulse |
| busy_o | output | 1 | Conversion in progress |
| adc_clk_en_o | output | 1 | Divided converter clock enable |
| high_speed_o | output | 1 | Registered high-speed status |

## Verification
The bench sends a second edge while a conversion is still busy. A design that queued the trigger would issue an extra start after done, and the count of starts would be one too high. The bench issues repeated sync edges in single-shot mode, both before and after a read strobe and an auto-mode toggle. This catches a block flag that never sets, never clears, or also gates ordinary sources. The bench switches the prescaler in the middle of a count and measures the delay to the first enable. A divider that did not restart would pulse early or late. Every prescaler code is measured over a fixed window, which catches a wrong factor such as code 0 dividing by 1.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int PRESC_W = 3;
  localparam int CNT_W   = (1 << PRESC_W) - 1;

  // terminal count of divider: factor-1, codes 0 and 1 both divide by 2
  function automatic logic [CNT_W-1:0] presc_last(input logic [PRESC_W-1:0] code);
    if (code == '0) return CNT_W'(1);
    return CNT_W'((1 << code) - 1);
  endfunction
endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
  parameter int SEL_W   = 4,
  parameter int NUM_EVT = 1 << SEL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] flags_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               rise_sel_o
);
  logic [NUM_EVT-1:0] prev_q;
  logic [NUM_EVT-1:0] rise;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[i] <= 1'b0;
      else         prev_q[i] <= flags_i[i];
    end
    assign rise[i] = flags_i[i] & ~prev_q[i];
  end

  assign rise_sel_o = rise[sel_i];
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic auto_en_i,
  input  logic single_shot_i,
  input  logic sync_src_i,
  input  logic rise_i,
  input  logic done_i,
  input  logic rd_hi_i,
  output logic soc_o,
  output logic busy_o
);
  logic soc_q, busy_q, blk_q;
  logic start;

  assign start = auto_en_i & rise_i & ~busy_q & ~blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      soc_q  <= 1'b0;
      busy_q <= 1'b0;
      blk_q  <= 1'b0;
    end else begin
      soc_q <= start;
      if (start)       busy_q <= 1'b1;
      else if (done_i) busy_q <= 1'b0;
      // clear dominates: read strobe or leaving auto mode
      if (rd_hi_i || !auto_en_i)                blk_q <= 1'b0;
      else if (start && single_shot_i && sync_src_i) blk_q <= 1'b1;
    end
  end

  assign soc_o  = soc_q;
  assign busy_o = busy_q;

  // R2
  soc_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) soc_q |=> !soc_q);
  // R5
  soc_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) soc_q |-> busy_q);
  // R5
  no_start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) soc_q |-> !$past(busy_q));
  // R6
  no_start_blk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) soc_q |-> !$past(blk_q));
  // R3
  start_auto_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) soc_q |-> $past(auto_en_i));
endmodule

// File: rtl/adc_trig_presc.sv
module adc_trig_presc
  import adc_trig_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] code_q_i,
  input  logic [PRESC_W-1:0] code_d_i,
  output logic               clk_en_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             code_chg;

  assign last     = presc_last(code_q_i);
  assign code_chg = code_d_i != code_q_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (code_chg)      cnt_q <= '0;
    else if (cnt_q == last) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign clk_en_o = cnt_q == last;

  // R10
  en_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) clk_en_o |=> !clk_en_o);
  // R11
  chg_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) code_chg |=> !clk_en_o);
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
#(
  parameter int             SEL_W      = 4,
  parameter int             NUM_EVT    = 1 << SEL_W,
  parameter logic [SEL_W-1:0] SYNC_SEL_A = SEL_W'(8),
  parameter logic [SEL_W-1:0] SYNC_SEL_B = SEL_W'(9)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               auto_en_i,
  input  logic [SEL_W-1:0]   trig_sel_i,
  input  logic               single_shot_i,
  input  logic [PRESC_W-1:0] presc_sel_i,
  input  logic               high_speed_i,
  input  logic [NUM_EVT-1:0] evt_flags_i,
  input  logic               res_hi_rd_i,
  input  logic               conv_done_i,
  output logic               soc_o,
  output logic               busy_o,
  output logic               adc_clk_en_o,
  output logic               high_speed_o
);
  logic               auto_q, ss_q, hs_q;
  logic [SEL_W-1:0]   sel_q;
  logic [PRESC_W-1:0] presc_q;
  logic               rise_sel, sync_src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_q  <= 1'b0;
      ss_q    <= 1'b0;
      hs_q    <= 1'b0;
      sel_q   <= '0;
      presc_q <= '0;
    end else begin
      auto_q  <= auto_en_i;
      ss_q    <= single_shot_i;
      hs_q    <= high_speed_i;
      sel_q   <= trig_sel_i;
      presc_q <= presc_sel_i;
    end
  end

  assign sync_src     = (sel_q == SYNC_SEL_A) || (sel_q == SYNC_SEL_B);
  assign high_speed_o = hs_q;

  adc_trig_edge #(.SEL_W(SEL_W), .NUM_EVT(NUM_EVT)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flags_i    (evt_flags_i),
    .sel_i      (sel_q),
    .rise_sel_o (rise_sel)
  );

  adc_trig_seq u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .auto_en_i     (auto_q),
    .single_shot_i (ss_q),
    .sync_src_i    (sync_src),
    .rise_i        (rise_sel),
    .done_i        (conv_done_i),
    .rd_hi_i       (res_hi_rd_i),
    .soc_o         (soc_o),
    .busy_o        (busy_o)
  );

  adc_trig_presc u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .code_q_i (presc_q),
    .code_d_i (presc_sel_i),
    .clk_en_o (adc_clk_en_o)
  );

  // R1
  always_comb begin
    if (!rst_ni) reset_out_chk: assert (!soc_o && !busy_o && !high_speed_o);
  end
endmodule

// File: tb/adc_trig_ctrl_tb.sv
module adc_trig_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        auto_en = 1'b0, single_shot = 1'b0, high_speed = 1'b0;
  logic [3:0]  trig_sel = '0;
  logic [2:0]  presc_sel = '0;
  logic [15:0] evt = '0;
  logic        rd_hi = 1'b0, done = 1'b0;
  logic        soc, busy, clk_en, hs;

  int checks = 0, fails = 0;
  int soc_cnt = 0, en_cnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_trig_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .auto_en_i(auto_en), .trig_sel_i(trig_sel),
    .single_shot_i(single_shot), .presc_sel_i(presc_sel), .high_speed_i(high_speed),
    .evt_flags_i(evt), .res_hi_rd_i(rd_hi), .conv_done_i(done),
    .soc_o(soc), .busy_o(busy), .adc_clk_en_o(clk_en), .high_speed_o(hs)
  );

  // behavioural reference model
  int   m_cnt;
  bit   m_soc, m_busy, m_blk, m_auto, m_ss, m_hs;
  int   m_sel, m_presc;
  bit [15:0] m_prev;

  function automatic int factor(int code);
    return (code == 0) ? 2 : (1 << code);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_soc = 0; m_busy = 0; m_blk = 0; m_auto = 0; m_ss = 0; m_hs = 0;
      m_sel = 0; m_presc = 0; m_prev = '0;
    end else begin
      bit edge_seen, go, sync;
      edge_seen = evt[m_sel] && !m_prev[m_sel];
      sync      = (m_sel == 8) || (m_sel == 9);
      go        = m_auto && edge_seen && !m_busy && !m_blk;
      m_soc     = go;
      if (go) m_busy = 1; else if (done) m_busy = 0;
      if (rd_hi || !m_auto) m_blk = 0; else if (go && m_ss && sync) m_blk = 1;
      if (int'(presc_sel) != m_presc) m_cnt = 0;
      else if (m_cnt == factor(m_presc) - 1) m_cnt = 0;
      else m_cnt++;
      m_prev = evt; m_auto = auto_en; m_ss = single_shot; m_hs = high_speed;
      m_sel = trig_sel; m_presc = presc_sel;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      check(!soc && !busy && !clk_en && !hs, "R1 reset outputs", {soc, busy, clk_en, hs}, 0);
    end else begin
      bit m_en;
      m_en = (m_cnt == factor(m_presc) - 1);
      check(soc == m_soc, "R2 soc_o", soc, m_soc);
      check(busy == m_busy, "R5 busy_o", busy, m_busy);
      check(clk_en == m_en, "R10 adc_clk_en_o", clk_en, m_en);
      check(hs == m_hs, "R12 high_speed_o", hs, m_hs);
      if (soc) soc_cnt++;
      if (clk_en) en_cnt++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_evt(input int idx);
    evt[idx] = 1'b1; cyc(1); evt[idx] = 1'b0; cyc(1);
  endtask

  task automatic finish_conv();
    cyc(3); done = 1'b1; cyc(1); done = 1'b0; cyc(1);
  endtask

  task automatic read_cnt(output int v);
    @(posedge clk); #1 v = soc_cnt;
    @(negedge clk);
  endtask

  initial begin
    int base, now;
    cyc(5);
    rst_n = 1'b1;
    cyc(2);
    // R2: basic trigger on source 3
    auto_en = 1; trig_sel = 4'd3; cyc(3);
    read_cnt(base);
    pulse_evt(3); finish_conv();
    read_cnt(now); check(now - base == 1, "R2 one start per edge", now - base, 1);
    // R4: unselected flag
    base = now; pulse_evt(5); pulse_evt(8); cyc(2);
    read_cnt(now); check(now == base, "R4 unselected ignored", now - base, 0);
    // R5: edge during busy dropped
    base = now; pulse_evt(3); cyc(1); pulse_evt(3); finish_conv(); cyc(3);
    read_cnt(now); check(now - base == 1, "R5 busy edge dropped", now - base, 1);
    // R3: auto off
    auto_en = 0; cyc(3); base = now; pulse_evt(3); cyc(3);
    read_cnt(now); check(now == base, "R3 auto off", now - base, 0);
    // R6: single shot on sync source 8
    auto_en = 1; single_shot = 1; trig_sel = 4'd8; cyc(3); base = now;
    pulse_evt(8); finish_conv(); pulse_evt(8); finish_conv();
    read_cnt(now); check(now - base == 1, "R6 single shot blocks", now - base, 1);
    rd_hi = 1; cyc(1); rd_hi = 0; cyc(1); base = now;
    pulse_evt(8); finish_conv();
    read_cnt(now); check(now - base == 1, "R6 read unblocks", now - base, 1);
    // R7: auto toggle clears block
    auto_en = 0; cyc(3); auto_en = 1; cyc(3); base = now;
    pulse_evt(8); finish_conv();
    read_cnt(now); check(now - base == 1, "R7 auto off clears block", now - base, 1);
    // R8: continuous on sync source 9
    single_shot = 0; trig_sel = 4'd9; rd_hi = 1; cyc(1); rd_hi = 0; cyc(2); base = now;
    pulse_evt(9); finish_conv(); pulse_evt(9); finish_conv();
    read_cnt(now); check(now - base == 2, "R8 continuous", now - base, 2);
    // R9: single shot on ordinary source
    single_shot = 1; trig_sel = 4'd3; cyc(3); base = now;
    pulse_evt(3); finish_conv(); pulse_evt(3); finish_conv();
    read_cnt(now); check(now - base == 2, "R9 single shot ignored", now - base, 2);
    // R10: every prescaler code
    for (int p = 0; p < 8; p++) begin
      int a, b;
      presc_sel = 3'(p); cyc(300);
      @(posedge clk); #1 a = en_cnt;
      repeat (512) @(posedge clk);
      #1 b = en_cnt;
      @(negedge clk);
      check(b - a == 512 / factor(p), "R10 division factor", b - a, 512 / factor(p));
    end
    // R11: mid-count change 7 -> 2
    cyc(37);
    begin
      int k;
      presc_sel = 3'd2; k = 0;
      do begin @(negedge clk); k++; end while (!clk_en && k < 300);
      check(k == 4, "R11 restart on change", k, 4);
      presc_sel = 3'd7; k = 0;
      do begin @(negedge clk); k++; end while (!clk_en && k < 300);
      check(k == 128, "R11 restart on change", k, 128);
    end
    // R12: high speed no effect on divider
    presc_sel = 3'd3; high_speed = 1; cyc(300);
    begin
      int a, b;
      @(posedge clk); #1 a = en_cnt;
      repeat (512) @(posedge clk);
      #1 b = en_cnt;
      @(negedge clk);
      check(b - a == 64, "R12 high speed no effect", b - a, 64);
      check(hs == 1'b1, "R12 status follows", hs, 1);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule